// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces the two mailbox interrupt flags of a two-port memory whose ports run on unrelated clocks. Each port has its own clock, active-low select, read/write strobe and word address, and each port owns one active-low interrupt output. The two highest addresses are reserved as mailboxes. Port A owns the word just below the top address. Port B owns the top word.

When one port writes the other port's mailbox, the owner's flag is raised. The owner lowers it again by reading its own mailbox. The mailbox data is held in the ordinary memory array, which sits outside this block. The block only watches the access strobes.

A write is seen as a toggle in the writer's clock domain. The toggle crosses to the owner's domain through a register chain, and an edge detector there turns it back into a one-cycle set pulse. A single enable input switches the whole function on or off. While it is low, both reserved words act as plain storage.

Top module: `mbox_irq`

## Requirements
- R1: When port B writes address 0x3FFE (b_sel_n = 0, b_rd_wr = 0), a_irq_n goes low within six port-A clock cycles after that port-B edge.
- R2: A port-A read of 0x3FFE (a_sel_n = 0, a_rd_wr = 1) drives a_irq_n high after the port-A edge that samples it, unless a set arrives on the same edge.
- R3: When port A writes address 0x3FFF (a_sel_n = 0, a_rd_wr = 0), b_irq_n goes low within six port-B clock cycles after that port-A edge.
- R4: A port-B read of 0x3FFF (b_sel_n = 0, b_rd_wr = 1) drives b_irq_n high after the port-B edge that samples it, unless a set arrives on the same edge.
- R5: Both interrupt outputs are active low, and each is driven high while its port's reset is low.
- R6: While irq_en is low, no access sets either flag, and a flag that is already set is released within one edge of its own clock. When irq_en returns high, a released flag stays released.
- R7: When a set and a clear of the same flag land on the same destination edge, the set wins and the flag stays low.
- R8: No other access changes a flag. This covers a port writing its own mailbox, a port reading the other port's mailbox, accesses to any other address, and accesses made with the select high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_sel_n | input | 1 | Port A select, active low |
| a_rd_wr | input | 1 | Port A access kind: 1 = read, 0 = write |
| a_addr | input | ADDR_W (14) | Port A word address |
| a_irq_n | output | 1 | Port A mailbox interrupt, active low |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_sel_n | input | 1 | Port B select, active low |
| b_rd_wr | input | 1 | Port B access kind: 1 = read, 0 = write |
| b_addr | input | ADDR_W (14) | Port B word address |
| b_irq_n | output | 1 | Port B mailbox interrupt, active low |
| irq_en | input | 1 | Interrupt function enable, active high |

## Verification
The properties make four assumptions about the inputs:
- irq_en changes only while no mailbox write is crossing between the domains.
- Both resets are asserted together.
- Every strobe is stable around the rising edge of its own port's clock.
- Successive writes to one mailbox are spaced several owner-clock cycles apart.

The stimulus meets these assumptions. Inputs change only on the falling edge of the driving port's clock. The enable changes only after every pending crossing has settled. Each mailbox write is followed by at least six owner-side cycles before the next access that concerns that flag.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

   // Access kind, encoded as the level of the read/write strobe.
   typedef enum logic {
      ACC_WRITE = 1'b0,
      ACC_READ  = 1'b1
   } acc_kind_e;

   localparam int unsigned NUM_PORTS = 2;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode #(
   parameter int unsigned             ADDR_W = 14,
   parameter logic [ADDR_W-1:0]       MATCH  = '1,
   parameter mbox_irq_pkg::acc_kind_e KIND   = mbox_irq_pkg::ACC_WRITE
) (
   input  logic              sel_n,
   input  logic              rd_wr,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   logic addr_eq;

   assign addr_eq = !sel_n && (addr == MATCH);

   generate
      if (KIND == mbox_irq_pkg::ACC_READ) begin : g_read
         assign hit = addr_eq && rd_wr;
      end else begin : g_write
         assign hit = addr_eq && !rd_wr;
      end
   endgenerate

endmodule

// File: rtl/mbox_evt_src.sv
module mbox_evt_src (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic fire,
   output logic tgl
);

   logic tgl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgl_q <= 1'b0;
      end else if (fire && en) begin
         tgl_q <= !tgl_q;
      end
   end

   assign tgl = tgl_q;

endmodule

// File: rtl/mbox_sync_pulse.sv
module mbox_sync_pulse #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_in,
   output logic pulse
);

   logic [STAGES-1:0] chain_q;
   logic              hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         hist_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], tgl_in};
         hist_q  <= chain_q[STAGES-1];
      end
   end

   assign pulse = chain_q[STAGES-1] ^ hist_q;

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic set,
   input  logic clr,
   output logic irq_n
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (!en) begin
         flag_q <= 1'b0;
      end else if (set) begin
         flag_q <= 1'b1;
      end else if (clr) begin
         flag_q <= 1'b0;
      end
   end

   assign irq_n = !flag_q;

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
   parameter int unsigned ADDR_W      = 14,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              a_clk,
   input  logic              a_rst_n,
   input  logic              a_sel_n,
   input  logic              a_rd_wr,
   input  logic [ADDR_W-1:0] a_addr,
   output logic              a_irq_n,
   input  logic              b_clk,
   input  logic              b_rst_n,
   input  logic              b_sel_n,
   input  logic              b_rd_wr,
   input  logic [ADDR_W-1:0] b_addr,
   output logic              b_irq_n,
   input  logic              irq_en
);

   localparam int unsigned NP = mbox_irq_pkg::NUM_PORTS;
   localparam logic [ADDR_W-1:0] MBOX_A = {{(ADDR_W-1){1'b1}}, 1'b0};
   localparam logic [ADDR_W-1:0] MBOX_B = {ADDR_W{1'b1}};

   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("mbox_irq: ADDR_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mbox_irq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              clk_v   [NP];
   logic              rst_v   [NP];
   logic              sel_n_v [NP];
   logic              rd_wr_v [NP];
   logic [ADDR_W-1:0] addr_v  [NP];
   logic              irq_n_v [NP];
   logic              own_rd  [NP];
   logic              peer_wr [NP];
   logic              tgl     [NP];
   logic              set_pls [NP];

   assign clk_v[0]   = a_clk;
   assign clk_v[1]   = b_clk;
   assign rst_v[0]   = a_rst_n;
   assign rst_v[1]   = b_rst_n;
   assign sel_n_v[0] = a_sel_n;
   assign sel_n_v[1] = b_sel_n;
   assign rd_wr_v[0] = a_rd_wr;
   assign rd_wr_v[1] = b_rd_wr;
   assign addr_v[0]  = a_addr;
   assign addr_v[1]  = b_addr;

   generate
      for (genvar p = 0; p < NP; p++) begin : g_port
         localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? MBOX_A : MBOX_B;
         localparam logic [ADDR_W-1:0] PEER = (p == 0) ? MBOX_B : MBOX_A;

         mbox_decode #(.ADDR_W(ADDR_W), .MATCH(OWN),
                       .KIND(mbox_irq_pkg::ACC_READ)) i_own_rd (
            .sel_n (sel_n_v[p]),
            .rd_wr (rd_wr_v[p]),
            .addr  (addr_v[p]),
            .hit   (own_rd[p])
         );

         mbox_decode #(.ADDR_W(ADDR_W), .MATCH(PEER),
                       .KIND(mbox_irq_pkg::ACC_WRITE)) i_peer_wr (
            .sel_n (sel_n_v[p]),
            .rd_wr (rd_wr_v[p]),
            .addr  (addr_v[p]),
            .hit   (peer_wr[p])
         );

         mbox_evt_src i_src (
            .clk   (clk_v[p]),
            .rst_n (rst_v[p]),
            .en    (irq_en),
            .fire  (peer_wr[p]),
            .tgl   (tgl[p])
         );

         mbox_sync_pulse #(.STAGES(SYNC_STAGES)) i_sync (
            .clk    (clk_v[p]),
            .rst_n  (rst_v[p]),
            .tgl_in (tgl[NP-1-p]),
            .pulse  (set_pls[p])
         );

         mbox_flag i_flag (
            .clk   (clk_v[p]),
            .rst_n (rst_v[p]),
            .en    (irq_en),
            .set   (set_pls[p]),
            .clr   (own_rd[p]),
            .irq_n (irq_n_v[p])
         );
      end
   endgenerate

   assign a_irq_n = irq_n_v[0];
   assign b_irq_n = irq_n_v[1];

   logic a_set_pls, b_set_pls, a_tgl, b_tgl;
   assign a_set_pls = set_pls[0];
   assign b_set_pls = set_pls[1];
   assign a_tgl     = tgl[0];
   assign b_tgl     = tgl[1];

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
   parameter int unsigned ADDR_W = 14
) (
   input logic              a_clk,
   input logic              a_rst_n,
   input logic              a_sel_n,
   input logic              a_rd_wr,
   input logic [ADDR_W-1:0] a_addr,
   input logic              a_irq_n,
   input logic              b_clk,
   input logic              b_rst_n,
   input logic              b_sel_n,
   input logic              b_rd_wr,
   input logic [ADDR_W-1:0] b_addr,
   input logic              b_irq_n,
   input logic              irq_en,
   input logic              a_set_pls,
   input logic              b_set_pls,
   input logic              a_tgl,
   input logic              b_tgl
);

   localparam logic [ADDR_W-1:0] MB_A = {{(ADDR_W-1){1'b1}}, 1'b0};
   localparam logic [ADDR_W-1:0] MB_B = {ADDR_W{1'b1}};

   logic a_rd_own, b_rd_own, a_wr_peer, b_wr_peer;
   assign a_rd_own  = !a_sel_n &&  a_rd_wr && (a_addr == MB_A);
   assign b_rd_own  = !b_sel_n &&  b_rd_wr && (b_addr == MB_B);
   assign a_wr_peer = !a_sel_n && !a_rd_wr && (a_addr == MB_B);
   assign b_wr_peer = !b_sel_n && !b_rd_wr && (b_addr == MB_A);

   assert_reset_a_R5: assert property (@(posedge a_clk) !a_rst_n |-> a_irq_n);
   assert_reset_b_R5: assert property (@(posedge b_clk) !b_rst_n |-> b_irq_n);

   assert_src_b_R1: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (b_wr_peer && irq_en) |=> (b_tgl != $past(b_tgl)));
   assert_src_a_R3: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      (a_wr_peer && irq_en) |=> (a_tgl != $past(a_tgl)));

   assert_clear_a_R2: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      (a_rd_own && !a_set_pls) |=> a_irq_n);
   assert_clear_b_R4: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (b_rd_own && !b_set_pls) |=> b_irq_n);

   assert_off_a_R6: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      !irq_en |=> a_irq_n);
   assert_off_b_R6: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      !irq_en |=> b_irq_n);

   assert_set_wins_a_R7: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      (a_set_pls && irq_en) |=> !a_irq_n);
   assert_set_wins_b_R7: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (b_set_pls && irq_en) |=> !b_irq_n);

   assert_fall_cause_a_R8: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      $fell(a_irq_n) |-> $past(a_set_pls));
   assert_fall_cause_b_R8: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      $fell(b_irq_n) |-> $past(b_set_pls));
   assert_hold_a_R8: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      (!a_irq_n && !a_rd_own && irq_en) |=> !a_irq_n);
   assert_hold_b_R8: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (!b_irq_n && !b_rd_own && irq_en) |=> !b_irq_n);

endmodule

bind mbox_irq mbox_irq_chk #(.ADDR_W(ADDR_W)) i_mbox_irq_chk (
   .a_clk     (a_clk),
   .a_rst_n   (a_rst_n),
   .a_sel_n   (a_sel_n),
   .a_rd_wr   (a_rd_wr),
   .a_addr    (a_addr),
   .a_irq_n   (a_irq_n),
   .b_clk     (b_clk),
   .b_rst_n   (b_rst_n),
   .b_sel_n   (b_sel_n),
   .b_rd_wr   (b_rd_wr),
   .b_addr    (b_addr),
   .b_irq_n   (b_irq_n),
   .irq_en    (irq_en),
   .a_set_pls (a_set_pls),
   .b_set_pls (b_set_pls),
   .a_tgl     (a_tgl),
   .b_tgl     (b_tgl)
);

// File: tb/test_mbox_irq.sv
module test_mbox_irq;

   localparam int unsigned AW = 14;
   localparam logic [AW-1:0] MB_A = 14'h3FFE;
   localparam logic [AW-1:0] MB_B = 14'h3FFF;

   logic          a_clk = 1'b0, b_clk = 1'b0, rst_n = 1'b0;
   logic          a_sel_n = 1'b1, a_rd_wr = 1'b1;
   logic          b_sel_n = 1'b1, b_rd_wr = 1'b1;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic          irq_en = 1'b1;
   logic          a_irq_n, b_irq_n;

   int runs  = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 a_clk = ~a_clk;
   always #13 b_clk = ~b_clk;

   mbox_irq #(.ADDR_W(AW), .SYNC_STAGES(2)) i_mbox_irq (
      .a_clk   (a_clk),
      .a_rst_n (rst_n),
      .a_sel_n (a_sel_n),
      .a_rd_wr (a_rd_wr),
      .a_addr  (a_addr),
      .a_irq_n (a_irq_n),
      .b_clk   (b_clk),
      .b_rst_n (rst_n),
      .b_sel_n (b_sel_n),
      .b_rd_wr (b_rd_wr),
      .b_addr  (b_addr),
      .b_irq_n (b_irq_n),
      .irq_en  (irq_en)
   );

   task automatic check(input string req, input logic act, input logic exp);
      runs++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // One access on port A: drive at falling edge, release at the next one.
   task automatic a_cycle(input logic rd, input logic [AW-1:0] ad, input logic sel_n);
      @(negedge a_clk);
      a_sel_n = sel_n; a_rd_wr = rd; a_addr = ad;
      @(negedge a_clk);
      a_sel_n = 1'b1; a_rd_wr = 1'b1; a_addr = '0;
   endtask

   task automatic b_cycle(input logic rd, input logic [AW-1:0] ad, input logic sel_n);
      @(negedge b_clk);
      b_sel_n = sel_n; b_rd_wr = rd; b_addr = ad;
      @(negedge b_clk);
      b_sel_n = 1'b1; b_rd_wr = 1'b1; b_addr = '0;
   endtask

   task automatic a_wait(input int n);
      repeat (n) @(negedge a_clk);
   endtask

   task automatic b_wait(input int n);
      repeat (n) @(negedge b_clk);
   endtask

   task automatic t_reset;
      check("R5 a_irq_n after reset", a_irq_n, 1'b1);
      check("R5 b_irq_n after reset", b_irq_n, 1'b1);
   endtask

   task automatic t_set_clear_a;
      b_cycle(1'b0, MB_A, 1'b0);
      a_wait(6);
      check("R1 a_irq_n after B write", a_irq_n, 1'b0);
      check("R8 b_irq_n untouched by B write", b_irq_n, 1'b1);
      b_cycle(1'b1, MB_A, 1'b0);
      a_cycle(1'b1, MB_B, 1'b0);
      a_cycle(1'b0, MB_A, 1'b0);
      a_cycle(1'b1, 14'h0123, 1'b0);
      a_cycle(1'b1, MB_A, 1'b1);
      a_wait(2);
      check("R8 a_irq_n kept by foreign accesses", a_irq_n, 1'b0);
      b_wait(6);
      check("R8 A writing own mailbox leaves b_irq_n", b_irq_n, 1'b1);
      a_cycle(1'b1, MB_A, 1'b0);
      check("R2 a_irq_n after A read", a_irq_n, 1'b1);
   endtask

   task automatic t_set_clear_b;
      a_cycle(1'b0, MB_B, 1'b0);
      b_wait(6);
      check("R3 b_irq_n after A write", b_irq_n, 1'b0);
      check("R8 a_irq_n untouched by A write", a_irq_n, 1'b1);
      b_cycle(1'b0, MB_B, 1'b0);
      a_cycle(1'b1, MB_B, 1'b0);
      b_wait(2);
      check("R8 b_irq_n kept by foreign accesses", b_irq_n, 1'b0);
      b_cycle(1'b1, MB_B, 1'b0);
      check("R4 b_irq_n after B read", b_irq_n, 1'b1);
   endtask

   task automatic t_no_set;
      b_cycle(1'b0, MB_A, 1'b1);
      b_cycle(1'b0, 14'h0005, 1'b0);
      a_cycle(1'b0, MB_A, 1'b1);
      a_wait(6);
      b_wait(6);
      check("R8 deselected/other-address writes a", a_irq_n, 1'b1);
      check("R8 deselected/other-address writes b", b_irq_n, 1'b1);
   endtask

   task automatic t_disable;
      @(negedge a_clk); irq_en = 1'b0;
      b_cycle(1'b0, MB_A, 1'b0);
      a_cycle(1'b0, MB_B, 1'b0);
      a_wait(6);
      b_wait(6);
      check("R6 disabled a_irq_n", a_irq_n, 1'b1);
      check("R6 disabled b_irq_n", b_irq_n, 1'b1);
      @(negedge a_clk); irq_en = 1'b1;
      a_wait(6);
      check("R6 no late set after enable", a_irq_n, 1'b1);
      b_cycle(1'b0, MB_A, 1'b0);
      a_wait(6);
      check("R1 a_irq_n set before disable", a_irq_n, 1'b0);
      irq_en = 1'b0;
      a_wait(2);
      check("R6 disable releases a_irq_n", a_irq_n, 1'b1);
      irq_en = 1'b1;
      a_wait(3);
      check("R6 released flag stays released", a_irq_n, 1'b1);
   endtask

   task automatic t_set_wins;
      int low_cycles;
      low_cycles = 0;
      @(negedge a_clk);
      a_sel_n = 1'b0; a_rd_wr = 1'b1; a_addr = MB_A;
      fork
         b_cycle(1'b0, MB_A, 1'b0);
         begin
            repeat (12) begin
               @(negedge a_clk);
               if (a_irq_n === 1'b0) low_cycles++;
            end
         end
      join
      a_sel_n = 1'b1; a_addr = '0;
      runs++;
      if (low_cycles != 1) begin
         fails++;
         $display("FAIL R7 set vs held read: actual %0d low cycles expected 1", low_cycles);
      end
      check("R7 flag cleared by held read afterwards", a_irq_n, 1'b1);
   endtask

   initial begin
      a_wait(3);
      rst_n = 1'b1;
      a_wait(2);
      t_reset();
      t_set_clear_a();
      t_set_clear_b();
      t_no_set();
      t_disable();
      t_set_wins();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge a_clk);
      if (!done) begin
         runs++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", runs, fails);
         $finish;
      end
   end

endmodule